// File: doc/BRIEF.md
# Path Signal Label Monitor

This block watches the path signal label byte that arrives once per frame. A new label value is not trusted as soon as it is seen. It becomes the accepted label only after the same byte has arrived in a programmable number of consecutive frames. This filters out single-frame bit errors before the value reaches software or the alarm logic.

The accepted label is compared with a programmable expected label, and two defects are derived from it. The unequipped defect is declared when the accepted label is all zeros. The payload label mismatch defect is declared when the accepted label differs from the expected one. The two defects are never raised together, and unequipped takes priority.

Every change of the accepted label sets a sticky change flag. That flag is gated by a mask bit to produce an interrupt, and it is cleared by a one-cycle clear strobe.

Top module: `path_label_monitor`

## Requirements
- R1: After reset the accepted label is 0x00, the change flag is 0, the interrupt is 0, the unequipped defect is 1 and the mismatch defect is 0.
- R2: The accepted label changes only on a clock edge where the valid strobe is high. On such an edge it takes the incoming byte when the run of identical consecutive valid bytes, counting this one, has reached the 4-bit persistence setting and the byte differs from the current accepted label.
- R3: A valid byte that differs from the current candidate byte restarts the run count at 1, with that byte as the new candidate. Frames without the valid strobe neither extend nor break the run.
- R4: A persistence setting of 0 behaves exactly like a setting of 1.
- R5: On the same edge that the accepted label changes, the change flag becomes 1.
- R6: The change flag stays at 1 until an edge where the clear strobe is high. When a label change and a clear fall on the same edge, the flag ends up at 1.
- R7: The interrupt equals the change flag while the mask input is 0, and is 0 while the mask input is 1.
- R8: The mismatch defect is 1 exactly when the accepted label is non-zero and differs from the expected label.
- R9: The unequipped defect is 1 exactly when the accepted label is 0x00. The two defects are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lbl_i | input | 8 | Label byte sampled for this frame |
| lbl_vld_i | input | 1 | One-cycle strobe marking lbl_i as this frame's label |
| exp_lbl_i | input | 8 | Expected label |
| persist_i | input | 4 | Consecutive identical frames required (0 acts as 1) |
| irq_mask_i | input | 1 | 1 blocks the interrupt |
| dlt_clr_i | input | 1 | Clears the change flag |
| acc_lbl_o | output | 8 | Accepted label |
| plm_o | output | 1 | Payload label mismatch defect |
| uneq_o | output | 1 | Unequipped defect |
| dlt_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
A wrong candidate or run count inside the filter stays hidden until it causes an acceptance. At that point the accepted label moves one or more valid frames too early or too late, and in the same edge the change flag rises or fails to rise. The defect outputs follow the accepted label in the same cycle by default. A wrong decode therefore shows immediately whenever the expected label or the accepted label is moved across the zero and match boundaries.

// File: rtl/plm_pkg.sv
package plm_pkg;

   // Defect pair produced from the accepted label
   typedef struct packed {
      logic uneq;
      logic plm;
   } plm_defect_t;

   // Saturating increment for the run counter
   function automatic logic [7:0] plm_sat_inc(input logic [7:0] v, input logic [7:0] max_v);
      return (v >= max_v) ? max_v : v + 8'd1;
   endfunction

endpackage

// File: rtl/plm_persist.sv
module plm_persist
   import plm_pkg::*;
#(
   parameter int LBL_W = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LBL_W-1:0] lbl_i,
   input  logic             lbl_vld_i,
   input  logic [CNT_W-1:0] persist_i,
   output logic [LBL_W-1:0] acc_o,
   output logic             chg_o
);
   localparam logic [7:0] RUN_MAX = 8'((1 << CNT_W) - 1);

   logic [LBL_W-1:0] cand_q, acc_q;
   logic [CNT_W-1:0] run_q, run_nx, thr;
   logic             hit;

   // Setting 0 is taken as 1
   assign thr    = (persist_i == '0) ? CNT_W'(1) : persist_i;
   assign run_nx = (lbl_i == cand_q) ? CNT_W'(plm_sat_inc(8'(run_q), RUN_MAX)) : CNT_W'(1);
   assign hit    = lbl_vld_i && (run_nx >= thr) && (lbl_i != acc_q);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cand_q <= '0;
         run_q  <= '0;
         acc_q  <= '0;
      end else if (lbl_vld_i) begin
         cand_q <= lbl_i;
         run_q  <= run_nx;
         if (hit) acc_q <= lbl_i;
      end
   end

   assign acc_o = acc_q;
   assign chg_o = hit;

   AST_NO_UPD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lbl_vld_i |=> $stable(acc_q)); // R2
   AST_RUN_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lbl_vld_i |=> (run_q != '0)); // R3
endmodule

// File: rtl/plm_defect.sv
module plm_defect
   import plm_pkg::*;
#(
   parameter int LBL_W = 8
) (
   input  logic [LBL_W-1:0] acc_i,
   input  logic [LBL_W-1:0] exp_i,
   output plm_defect_t      dfc_o
);
   logic zero;

   assign zero       = (acc_i == '0);
   // Unequipped has priority, so mismatch is suppressed on an all-zero label
   assign dfc_o.uneq = zero;
   assign dfc_o.plm  = !zero && (acc_i != exp_i);

   always_comb begin
      AST_DEFECT_EXCL: assert (!(dfc_o.uneq && dfc_o.plm)); // R9
   end
endmodule

// File: rtl/path_label_monitor.sv
module path_label_monitor
   import plm_pkg::*;
#(
   parameter int LBL_W    = 8,
   parameter int CNT_W    = 4,
   parameter bit REG_DFCT = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LBL_W-1:0] lbl_i,
   input  logic             lbl_vld_i,
   input  logic [LBL_W-1:0] exp_lbl_i,
   input  logic [CNT_W-1:0] persist_i,
   input  logic             irq_mask_i,
   input  logic             dlt_clr_i,
   output logic [LBL_W-1:0] acc_lbl_o,
   output logic             plm_o,
   output logic             uneq_o,
   output logic             dlt_o,
   output logic             irq_o
);
   if (LBL_W < 1 || LBL_W > 32) begin : g_bad_lbl
      $error("LBL_W out of range");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W out of range");
   end

   logic [LBL_W-1:0] acc;
   logic             chg, dlt_q;
   plm_defect_t      dfc;

   plm_persist #(.LBL_W(LBL_W), .CNT_W(CNT_W)) u_persist (
      .clk_i(clk_i), .rst_ni(rst_ni), .lbl_i(lbl_i), .lbl_vld_i(lbl_vld_i),
      .persist_i(persist_i), .acc_o(acc), .chg_o(chg));

   plm_defect #(.LBL_W(LBL_W)) u_defect (
      .acc_i(acc), .exp_i(exp_lbl_i), .dfc_o(dfc));

   if (REG_DFCT) begin : g_dfct_reg
      plm_defect_t dfc_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) dfc_q <= '{uneq: 1'b1, plm: 1'b0};
         else         dfc_q <= dfc;
      end
      assign uneq_o = dfc_q.uneq;
      assign plm_o  = dfc_q.plm;
   end else begin : g_dfct_comb
      assign uneq_o = dfc.uneq;
      assign plm_o  = dfc.plm;
   end

   // Sticky change flag, set beats clear
   always_ff @(posedge clk_i) begin
      if (!rst_ni)        dlt_q <= 1'b0;
      else if (chg)       dlt_q <= 1'b1;
      else if (dlt_clr_i) dlt_q <= 1'b0;
   end

   assign acc_lbl_o = acc;
   assign dlt_o     = dlt_q;
   assign irq_o     = dlt_q && !irq_mask_i;

   AST_DLT_ON_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(acc) |-> dlt_q); // R5
   AST_DLT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dlt_q && !dlt_clr_i) |=> dlt_q); // R6
endmodule

// File: tb/sim_path_label_monitor.sv
module sim_path_label_monitor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] lbl = '0, exp_lbl = '0;
   logic       vld = 1'b0, mask = 1'b0, clr = 1'b0;
   logic [3:0] pers = 4'd1;
   logic [7:0] acc;
   logic       plm, uneq, dlt, irq;

   int n_chk = 0, n_fail = 0, cyc = 0;

   // Reference state
   logic [7:0] m_cand = '0, m_acc = '0;
   int         m_run = 0;
   logic       m_dlt = 1'b0;

   always #5 clk = ~clk;

   path_label_monitor u0 (
      .clk_i(clk), .rst_ni(rst_n), .lbl_i(lbl), .lbl_vld_i(vld), .exp_lbl_i(exp_lbl),
      .persist_i(pers), .irq_mask_i(mask), .dlt_clr_i(clr), .acc_lbl_o(acc),
      .plm_o(plm), .uneq_o(uneq), .dlt_o(dlt), .irq_o(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   function automatic logic f_plm(input logic [7:0] a, input logic [7:0] e);
      return (a != 8'h00) && (a != e);
   endfunction

   function automatic logic f_irq(input logic d, input logic m);
      return d && !m;
   endfunction

   task automatic model_edge();
      int  nrun, thr;
      logic chg;
      chg = 1'b0;
      if (vld) begin
         nrun = (lbl == m_cand) ? ((m_run >= 15) ? 15 : m_run + 1) : 1;
         thr  = (pers == 0) ? 1 : int'(pers);
         chg  = (nrun >= thr) && (lbl != m_acc);
         m_cand = lbl;
         m_run  = nrun;
         if (chg) m_acc = lbl;
      end
      if (chg) m_dlt = 1'b1;
      else if (clr) m_dlt = 1'b0;
   endtask

   task automatic compare_all();
      chk("R2", 32'(acc), 32'(m_acc));
      chk("R5", 32'(dlt), 32'(m_dlt));
      chk("R7", 32'(irq), 32'(f_irq(m_dlt, mask)));
      chk("R8", 32'(plm), 32'(f_plm(m_acc, exp_lbl)));
      chk("R9", 32'(uneq), 32'(m_acc == 8'h00));
   endtask

   // Called at a falling edge: drive, take one rising edge, compare at next falling edge
   task automatic step(input logic [7:0] b, input logic v, input logic c);
      lbl = b; vld = v; clr = c;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      vld = 1'b0; clr = 1'b0;
      compare_all();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0] pick;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", 32'(acc), 32'h00);
      chk("R1", 32'(dlt), 32'd0);
      chk("R1", 32'(irq), 32'd0);
      chk("R1", 32'(uneq), 32'd1);
      chk("R1", 32'(plm), 32'd0);

      // R2: persistence 3 needs three identical frames
      pers = 4'd3; exp_lbl = 8'h1A;
      step(8'h1A, 1, 0); step(8'h1A, 1, 0);
      chk("R2", 32'(acc), 32'h00);
      step(8'h1A, 0, 0);                 // idle frame keeps run
      chk("R3", 32'(acc), 32'h00);
      step(8'h1A, 1, 0);
      chk("R2", 32'(acc), 32'h1A);
      chk("R5", 32'(dlt), 32'd1);
      chk("R8", 32'(plm), 32'd0);

      // R6 clear, R7 mask
      mask = 1'b1; #1;
      chk("R7", 32'(irq), 32'd0);
      mask = 1'b0;
      step(8'h1A, 0, 1);
      chk("R6", 32'(dlt), 32'd0);

      // R3: a different byte restarts the run
      step(8'h33, 1, 0); step(8'h33, 1, 0); step(8'h44, 1, 0);
      step(8'h33, 1, 0); step(8'h33, 1, 0);
      chk("R3", 32'(acc), 32'h1A);
      step(8'h33, 1, 1);                 // change and clear together
      chk("R3", 32'(acc), 32'h33);
      chk("R6", 32'(dlt), 32'd1);
      chk("R8", 32'(plm), 32'd1);

      // R4: setting 0 accepts on one frame
      pers = 4'd0;
      step(8'h00, 1, 1);
      chk("R4", 32'(acc), 32'h00);
      chk("R9", 32'(uneq), 32'd1);
      chk("R9", 32'(plm), 32'd0);

      // Random traffic
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 49) == 0) pers = 4'($urandom_range(0, 5));
         if ($urandom_range(0, 99) == 0) exp_lbl = ($urandom_range(0, 1) != 0) ? 8'h1A : 8'($urandom);
         mask = ($urandom_range(0, 3) == 0);
         case ($urandom_range(0, 3))
            0: pick = 8'h00;
            1: pick = 8'h1A;
            2: pick = exp_lbl;
            default: pick = 8'($urandom);
         endcase
         step(pick, $urandom_range(0, 9) < 7, $urandom_range(0, 19) == 0);
      end
      finish_run();
   end
endmodule